// File: doc/BRIEF.md
# Multi-mode receive word aligner

The aligner sits on a receive datapath behind a deserializer. It turns a stream of parallel words, whose boundaries land at an arbitrary bit phase, into words that start on a chosen bit. The interface is either 8 or 10 bits wide. The block keeps the last two input words and joins them with the current word into one bit window. The first serial bit is the LSB of each word and the oldest word is at the bottom of the window. The aligned word is taken from that window at the current bit offset.

In slip mode, fabric logic moves the boundary one bit at a time with a request line, and the status flags stay low. In pattern mode, the block compares a programmable pattern against every bit offset, locks onto the lowest offset that matches and reports two things: each new lock, and each pattern occurrence at the current boundary. On the 8-bit interface a rising edge of the enable starts a search, which runs until the first match. On the 10-bit interface the enable is a level, and realignment is allowed for as long as it is high.

Top module: `rx_word_aligner`

## Requirements
- R1: While rst_ni is low and after its release, data_o, sync_o and pdet_o are 0, the bit offset is 0 and no search is armed.
- R2: With W = 8 (wide_i=0) or 10 (wide_i=1), data_o one cycle after a clock edge equals bits [off+W-1:off] of {data_i, previous data_i}, using the low W bits of each input word. Here off is the offset in effect at that edge. When wide_i=0, data_o[9:8] are 0 and data_i[9:8] are ignored.
- R3: In slip mode (mode_i=0), each 0-to-1 transition of bitslip_i raises the offset by one, and the offset wraps from W-1 to 0. The new offset takes effect at the following clock edge. Without such a transition the offset holds.
- R4: In slip mode, align_en_i and pattern_i have no effect, and sync_o and pdet_o stay 0.
- R5: In pattern mode (mode_i=1) with wide_i=0, a rising edge of align_en_i arms a search. The search stays armed, at whatever level align_en_i has, until the first cycle in which some offset matches, and then locks onto it. After that, matches at other offsets leave the offset unchanged until the next rising edge.
- R6: In pattern mode with wide_i=1, a search is active in every cycle in which align_en_i is high. It locks whenever the lowest matching offset differs from the current offset. With align_en_i low, no lock occurs.
- R7: In pattern mode, sync_o is 1 for exactly the one cycle after each lock. That cycle's data_o already uses the new offset.
- R8: In pattern mode, pdet_o is 1 for the one cycle after each edge at which the pattern matches at the offset in effect.
- R9: The pattern length P is chosen by plen_long_i. With wide_i=0, plen_long_i=0 gives 8 and plen_long_i=1 gives 16. With wide_i=1, plen_long_i=0 gives 7 and plen_long_i=1 gives 10. Only pattern_i[P-1:0] is compared, and pattern_i bit 0 is the first serial bit.
- R10: For P=16 on the 8-bit interface, a match needs the low pattern byte in the previous aligned word and the high byte in the current aligned word. pdet_o fires in the cycle after the second byte is seen.
- R11: When several offsets match at once, the lowest offset is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 slip mode, 1 pattern mode |
| wide_i | input | 1 | 0 8-bit words, 1 10-bit words |
| plen_long_i | input | 1 | Selects the longer pattern length |
| align_en_i | input | 1 | Search enable (edge on 8-bit, level on 10-bit) |
| bitslip_i | input | 1 | Slip request, acts on 0-to-1 transitions |
| pattern_i | input | 16 | Alignment pattern, bit 0 first |
| data_i | input | 10 | Raw parallel word, bit 0 first |
| data_o | output | 10 | Aligned word |
| sync_o | output | 1 | One-cycle pulse on a new lock |
| pdet_o | output | 1 | One-cycle pulse on a pattern at the current boundary |

## Verification
The properties assume that mode_i, wide_i and plen_long_i change only while the block is held in reset. If they did, the offset could exceed W-1 for the new width, and the slip step and wrap would no longer mean anything. The stimulus therefore fixes these three inputs for each run and resets before every run. Within a run it moves bitslip_i, align_en_i, data_i and, in slip mode, pattern_i freely from cycle to cycle.

// File: rtl/rxwa_pkg.sv
package rxwa_pkg;
  typedef enum logic {
    MODE_SLIP   = 1'b0,
    MODE_MANUAL = 1'b1
  } wa_mode_e;
endpackage

// File: rtl/rxwa_history.sv
module rxwa_history #(
  parameter int unsigned DW = 10,
  parameter int unsigned NW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wide_i,
  input  logic [DW-1:0]   data_i,
  output logic [3*DW-1:0] win_o
);
  localparam int unsigned PADW = 3 * (DW - NW);

  logic [DW-1:0] p1_q, p2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
      p2_q <= '0;
    end else begin
      p1_q <= data_i;
      p2_q <= p1_q;
    end
  end

  // oldest word at the bottom, current word on top
  generate
    if (PADW > 0) begin : g_pad
      always_comb begin
        if (wide_i) win_o = {data_i, p1_q, p2_q};
        else        win_o = {{PADW{1'b0}}, data_i[NW-1:0], p1_q[NW-1:0], p2_q[NW-1:0]};
      end
    end else begin : g_nopad
      assign win_o = {data_i, p1_q, p2_q};
    end
  endgenerate
endmodule

// File: rtl/rxwa_matcher.sv
module rxwa_matcher #(
  parameter int unsigned DW      = 10,
  parameter int unsigned NW      = 8,
  parameter int unsigned PW      = 16,
  parameter int unsigned PLEN_NS = 8,
  parameter int unsigned PLEN_NL = 16,
  parameter int unsigned PLEN_WS = 7,
  parameter int unsigned PLEN_WL = 10
) (
  input  logic [3*DW-1:0] win_i,
  input  logic [PW-1:0]   pattern_i,
  input  logic            wide_i,
  input  logic            plen_long_i,
  output logic [DW-1:0]   hit_o
);
  localparam int unsigned EXTW = 3 * DW + PW;

  logic [EXTW-1:0] ext;
  logic [PW-1:0]   mask;
  int unsigned     wlen, plen, back;

  always_comb begin
    wlen = wide_i ? DW : NW;
    if (wide_i) plen = plen_long_i ? PLEN_WL : PLEN_WS;
    else        plen = plen_long_i ? PLEN_NL : PLEN_NS;
    // a pattern longer than a word ends in the current aligned word
    back = (plen > wlen) ? wlen : 0;
    mask = (PW'(1) << plen) - PW'(1);
    ext  = {{PW{1'b0}}, win_i};
  end

  generate
    for (genvar k = 0; k < DW; k++) begin : g_off
      int unsigned   st;
      logic [PW-1:0] seg;
      always_comb begin
        st       = wlen + k - back;
        seg      = ext[st +: PW];
        hit_o[k] = (k < wlen) && (((seg ^ pattern_i) & mask) == '0);
      end
    end
  endgenerate
endmodule

// File: rtl/rxwa_ctrl.sv
module rxwa_ctrl
  import rxwa_pkg::*;
#(
  parameter int unsigned DW   = 10,
  parameter int unsigned NW   = 8,
  parameter int unsigned OFFW = $clog2(DW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  wa_mode_e        mode_i,
  input  logic            wide_i,
  input  logic            align_en_i,
  input  logic            bitslip_i,
  input  logic [DW-1:0]   hit_i,
  output logic [OFFW-1:0] off_eff_o,
  output logic [OFFW-1:0] off_q_o,
  output logic            sync_o,
  output logic            pdet_o
);
  localparam int unsigned HW = 1 << OFFW;

  logic [OFFW-1:0] off_q, off_d, low, wlast;
  logic            armed_q, armed_d, en_q, slip_q;
  logic            sync_d, pdet_d, any, search, slip_rise, en_rise;
  logic [HW-1:0]   hit_ext;

  always_comb begin
    hit_ext   = HW'(hit_i);
    wlast     = wide_i ? OFFW'(DW - 1) : OFFW'(NW - 1);
    any       = |hit_i;
    low       = '0;
    for (int k = DW - 1; k >= 0; k--) if (hit_i[k]) low = OFFW'(k);
    slip_rise = bitslip_i & ~slip_q;
    en_rise   = align_en_i & ~en_q;
    off_d     = off_q;
    off_eff_o = off_q;
    armed_d   = 1'b0;
    search    = 1'b0;
    sync_d    = 1'b0;
    pdet_d    = 1'b0;
    if (mode_i == MODE_SLIP) begin
      if (slip_rise) off_d = (off_q == wlast) ? '0 : off_q + OFFW'(1);
    end else begin
      search  = wide_i ? align_en_i : (armed_q | en_rise);
      sync_d  = search & any & (~wide_i | (low != off_q));
      armed_d = ~wide_i & search & ~any;
      if (sync_d) begin
        off_d     = low;
        off_eff_o = low;
      end
      pdet_d = hit_ext[off_eff_o];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q   <= '0;
      armed_q <= 1'b0;
      en_q    <= 1'b0;
      slip_q  <= 1'b0;
      sync_o  <= 1'b0;
      pdet_o  <= 1'b0;
    end else begin
      off_q   <= off_d;
      armed_q <= armed_d;
      en_q    <= align_en_i;
      slip_q  <= bitslip_i;
      sync_o  <= sync_d;
      pdet_o  <= pdet_d;
    end
  end

  assign off_q_o = off_q;
endmodule

// File: rtl/rxwa_shifter.sv
module rxwa_shifter #(
  parameter int unsigned DW   = 10,
  parameter int unsigned NW   = 8,
  parameter int unsigned OFFW = $clog2(DW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wide_i,
  input  logic [3*DW-1:0] win_i,
  input  logic [OFFW-1:0] off_i,
  output logic [DW-1:0]   data_o
);
  int unsigned   sh;
  logic [DW-1:0] part, data_d;

  always_comb begin
    sh     = (wide_i ? DW : NW) + int'(off_i);
    part   = win_i[sh +: DW];
    data_d = wide_i ? part : DW'(part[NW-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= data_d;
  end
endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner
  import rxwa_pkg::*;
#(
  parameter int unsigned DW      = 10,
  parameter int unsigned NW      = 8,
  parameter int unsigned PW      = 16,
  parameter int unsigned PLEN_NS = 8,
  parameter int unsigned PLEN_NL = 16,
  parameter int unsigned PLEN_WS = 7,
  parameter int unsigned PLEN_WL = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          wide_i,
  input  logic          plen_long_i,
  input  logic          align_en_i,
  input  logic          bitslip_i,
  input  logic [PW-1:0] pattern_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          sync_o,
  output logic          pdet_o
);
  localparam int unsigned OFFW = $clog2(DW);

  logic [3*DW-1:0] win;
  logic [DW-1:0]   hit;
  logic [OFFW-1:0] off_eff, off_q;
  wa_mode_e        mode;

  assign mode = wa_mode_e'(mode_i);

  rxwa_history #(.DW(DW), .NW(NW)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i), .data_i(data_i), .win_o(win)
  );

  rxwa_matcher #(
    .DW(DW), .NW(NW), .PW(PW), .PLEN_NS(PLEN_NS), .PLEN_NL(PLEN_NL),
    .PLEN_WS(PLEN_WS), .PLEN_WL(PLEN_WL)
  ) u_match (
    .win_i(win), .pattern_i(pattern_i), .wide_i(wide_i),
    .plen_long_i(plen_long_i), .hit_o(hit)
  );

  rxwa_ctrl #(.DW(DW), .NW(NW), .OFFW(OFFW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .wide_i(wide_i),
    .align_en_i(align_en_i), .bitslip_i(bitslip_i), .hit_i(hit),
    .off_eff_o(off_eff), .off_q_o(off_q), .sync_o(sync_o), .pdet_o(pdet_o)
  );

  rxwa_shifter #(.DW(DW), .NW(NW), .OFFW(OFFW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i), .win_i(win),
    .off_i(off_eff), .data_o(data_o)
  );
endmodule

// File: rtl/rx_word_aligner_chk.sv
module rx_word_aligner_chk #(
  parameter int unsigned DW   = 10,
  parameter int unsigned NW   = 8,
  parameter int unsigned OFFW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mode_i,
  input logic            wide_i,
  input logic            align_en_i,
  input logic [DW-1:0]   data_o,
  input logic            sync_o,
  input logic            pdet_o,
  input logic [OFFW-1:0] off_q
);
  AST_SLIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> (!sync_o && !pdet_o)); // R4

  AST_SYNC_WITH_PDET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> pdet_o); // R7

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |=> (data_o[DW-1:NW] == '0)); // R2

  AST_LEVEL_IDLE_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && wide_i && !align_en_i) |=> !sync_o); // R6

  AST_SLIP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> ((off_q == $past(off_q)) || (off_q == $past(off_q) + OFFW'(1)) ||
                 (off_q == '0))); // R3
endmodule

bind rx_word_aligner rx_word_aligner_chk #(.DW(DW), .NW(NW), .OFFW(OFFW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .wide_i(wide_i),
  .align_en_i(align_en_i), .data_o(data_o), .sync_o(sync_o), .pdet_o(pdet_o),
  .off_q(off_q)
);

// File: tb/rx_word_aligner_bench.sv
`timescale 1ns/1ps
module rx_word_aligner_bench;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0, wide = 1'b0, plong = 1'b0, en = 1'b0, slip = 1'b0;
  logic [15:0]   pat = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          sync, pdet;

  always #2 clk = ~clk;

  rx_word_aligner u_rx_word_aligner (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .wide_i(wide), .plen_long_i(plong),
    .align_en_i(en), .bitslip_i(slip), .pattern_i(pat), .data_i(din),
    .data_o(dout), .sync_o(sync), .pdet_o(pdet)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  // reference model, from the requirements
  logic [DW-1:0] m_p1, m_p2, e_data;
  logic          e_sync, e_pdet, m_armed, m_en, m_slip;
  int            m_off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = '0; m_p2 = '0; e_data = '0; e_sync = 0; e_pdet = 0;
      m_armed = 0; m_en = 0; m_slip = 0; m_off = 0;
    end else begin
      int w, p, back, lowk, offe;
      bit any, lock, srch;
      logic [63:0] bits;
      bit hit[DW];
      w = wide ? 10 : 8;
      p = wide ? (plong ? 10 : 7) : (plong ? 16 : 8);
      back = (p > w) ? w : 0;
      bits = '0;
      for (int i = 0; i < w; i++) begin
        bits[i] = m_p2[i]; bits[w+i] = m_p1[i]; bits[2*w+i] = din[i];
      end
      any = 0; lowk = 0;
      for (int k = DW - 1; k >= 0; k--) begin
        hit[k] = (k < w);
        for (int j = 0; j < p; j++)
          if (bits[w + k - back + j] != pat[j]) hit[k] = 0;
        if (hit[k]) begin any = 1; lowk = k; end
      end
      offe = m_off; e_sync = 0; e_pdet = 0;
      if (!mode) begin
        if (slip && !m_slip) m_off = (m_off == w - 1) ? 0 : m_off + 1;
        m_armed = 0;
      end else begin
        srch = wide ? en : (m_armed || (en && !m_en));
        lock = srch && any && (!wide || lowk != m_off);
        m_armed = !wide && srch && !any;
        if (lock) begin m_off = lowk; offe = lowk; end
        e_sync = lock;
        e_pdet = hit[offe];
      end
      e_data = '0;
      for (int i = 0; i < w; i++) e_data[i] = bits[w + offe + i];
      m_p2 = m_p1; m_p1 = din; m_en = en; m_slip = slip;
    end
  end

  // serial bit source
  logic [63:0] sbuf = '0;
  int          scnt = 0;
  bit          alt_ph = 0;

  task automatic push(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) begin
      sbuf[scnt] = v[i];
      scnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; slip = 0; en = 0;
    @(negedge clk);
    chk("R1 data", 32'(dout), 0);
    chk("R1 sync", 32'(sync), 0);
    chk("R1 pdet", 32'(pdet), 0);
    rst_n = 1;
  endtask

  task automatic run(string t, bit md, bit wd, bit pl, int n, bit alt, logic [15:0] pv);
    int w, p;
    mode = md; wide = wd; plong = pl; pat = pv;
    w = wd ? 10 : 8;
    p = wd ? (pl ? 10 : 7) : (pl ? 16 : 8);
    do_reset();
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk({t, " data"}, 32'(dout), 32'(e_data));
      chk({t, " sync"}, 32'(sync), 32'(e_sync));
      chk({t, " pdet"}, 32'(pdet), 32'(e_pdet));
      while (scnt < w) begin
        if (alt) begin push(16'(alt_ph), 1); alt_ph = ~alt_ph; end
        else if (md && ($urandom % 12 == 0)) push(pv, p);
        else push(16'($urandom % 2), 1);
      end
      din = DW'($urandom);
      for (int i = 0; i < w; i++) din[i] = sbuf[i];
      sbuf = sbuf >> w; scnt -= w;
      if ($urandom % 6 == 0) slip = ~slip;
      if (!md) begin
        en = 1'($urandom);
        pat = 16'($urandom);
      end else if ($urandom % (wd ? 25 : 15) == 0) en = ~en;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0a11));
    do_reset();
    run("R3 R4 slip narrow", 0, 0, 0, 400, 0, 16'h0);
    run("R3 R4 slip wide", 0, 1, 0, 400, 0, 16'h0);
    run("R2 slip narrow offset0", 0, 0, 0, 40, 0, 16'h0);
    run("R5 R7 R8 narrow p8", 1, 0, 0, 500, 0, 16'hA6C4);
    run("R9 R10 narrow p16", 1, 0, 1, 500, 0, 16'hF628);
    run("R6 R7 R8 wide p7", 1, 1, 0, 500, 0, 16'h3C5B);
    run("R9 wide p10", 1, 1, 1, 500, 0, 16'h8E2D);
    run("R11 lowest offset narrow", 1, 0, 0, 150, 1, 16'h0055);
    run("R11 lowest offset wide", 1, 1, 1, 150, 1, 16'hFD55);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule